// File: doc/BRIEF.md
# Two-Wide Physical Register Rename Unit

This block sits in the decode stage of an out-of-order core that keeps committed and speculative values in one physical register file. Each cycle it accepts a group of up to two decoded instructions, replaces every architectural source with the physical tag that holds its newest value, and gives every register-writing instruction a fresh physical destination taken from a free list. For each renamed instruction it also returns the physical tag that its destination mapped to before the rename. No operand data passes through the block; only tags move.

The previous tag travels with the instruction. When a later writer of the same architectural register commits, the core sends that previous tag back on the commit port and it rejoins the free list. On a trap the core replays the uncommitted writers from youngest to oldest on the recovery port. Each replay restores the saved mapping in the table and returns the speculative destination to the free list. When the free list is too short for the group, or while recovery runs, the block raises a stall and renames nothing.

Top module: `phys_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers 32 to 63 and hands them out in ascending order. Stall is low and no output lane is valid.
- R2: A source operand is renamed to the physical tag currently mapped to its architectural register.
- R3: A lane that writes a register takes the tag at the head of the free list. Lane 0 takes it before lane 1. The rename table then maps the destination to that tag, and the two lanes of one group never get the same tag.
- R4: The previous-tag output of a writing lane equals the mapping its destination had just before that lane's rename.
- R5: Inside one group, a lane 1 source that names lane 0's destination gets lane 0's new tag. If both lanes write the same register, lane 1's previous tag is lane 0's new tag and lane 1's mapping wins in the table.
- R6: Architectural register 0 always renames to physical tag 0. A destination of register 0 allocates nothing and reports tag 0 as both destination and previous tag.
- R7: A lane without a destination allocates nothing and reports tag 0 as destination and previous tag.
- R8: When any input lane is valid and the free list holds fewer tags than the group's writers need, stall is high in the same cycle. No lane is renamed, and the table and free list keep their state.
- R9: Each valid commit lane with a nonzero tag appends that tag to the tail of the free list. Commit lane 0 is appended before commit lane 1.
- R10: A recovery request writes its saved previous tag into the table entry of its architectural register. It appends its speculative destination to the free list after any same-cycle commit tags. While it is active, stall is high whenever an input lane is valid.
- R11: Rename results are registered. The output lanes show a group in the cycle after the clock edge that accepted it, and an output lane is valid only for an accepted valid input lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Per-lane instruction valid |
| in_has_dst | input | 2 | Per-lane flag that the instruction writes a register |
| in_dst | input | 10 | Per-lane destination architectural register, lane 0 in bits 4:0 |
| in_src1 | input | 10 | Per-lane first source architectural register |
| in_src2 | input | 10 | Per-lane second source architectural register |
| stall | output | 1 | Group not accepted this cycle |
| out_valid | output | 2 | Per-lane renamed result valid |
| out_psrc1 | output | 12 | Per-lane first source physical tag, lane 0 in bits 5:0 |
| out_psrc2 | output | 12 | Per-lane second source physical tag |
| out_pdst | output | 12 | Per-lane new destination physical tag |
| out_pold | output | 12 | Per-lane previous destination physical tag |
| cmt_valid | input | 2 | Per-lane commit that frees a tag |
| cmt_tag | input | 12 | Per-lane tag to free |
| rec_valid | input | 1 | Undo one rename, youngest first |
| rec_arch | input | 5 | Architectural destination of the undone instruction |
| rec_pold | input | 6 | Previous tag to restore |
| rec_pdst | input | 6 | Speculative tag to free |

## Verification
A corrupted table entry shows up as a wrong source or previous tag on the next instruction that reads that register. A free list that drops, duplicates or reorders a tag shows up as a wrong destination tag once allocation reaches that slot, which may be up to 32 allocations after the fault. The bench keeps the mapping, the free list and the in-flight writers as plain arrays and queues. It compares stall in the cycle it is driven and every output lane one edge later. Long runs without commits drain the free list so that stalls and wrap-around get exercised. Recovery bursts follow, and later renames prove the restored mappings and the order in which tags returned.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // lanes in one decode group and in the commit port
  localparam int GROUP = 2;
  // rename table read ports: two sources and the old destination per lane
  localparam int NRD = 3 * GROUP;
  // free list push slots: commit lanes then one recovery slot
  localparam int NPUSH = GROUP + 1;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int PW       = 6,
  localparam int AW      = $clog2(NUM_ARCH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][AW-1:0]    rd_arch,
  output logic [NRD-1:0][PW-1:0]    rd_tag,
  input  logic [GROUP-1:0]          wr_en,
  input  logic [GROUP-1:0][AW-1:0]  wr_arch,
  input  logic [GROUP-1:0][PW-1:0]  wr_tag,
  input  logic                      rec_en,
  input  logic [AW-1:0]             rec_arch,
  input  logic [PW-1:0]             rec_tag
);
  logic [PW-1:0] tbl [NUM_ARCH];

  // later lanes override earlier ones; recovery never shares a cycle with rename
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ARCH; i++) tbl[i] <= PW'(i);
    end else begin
      for (int g = 0; g < GROUP; g++)
        if (wr_en[g] && wr_arch[g] != '0) tbl[wr_arch[g]] <= wr_tag[g];
      if (rec_en && rec_arch != '0) tbl[rec_arch] <= rec_tag;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_tag[r] = (rd_arch[r] == '0) ? '0 : tbl[rd_arch[r]];
  end

  assert_rec_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(rec_en && (|wr_en)));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rename_pkg::*;
#(
  parameter int NUM_PHYS  = 64,
  parameter int INIT_FREE = 32,
  parameter int FIRST_TAG = 32,
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int CW       = PW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [GROUP-1:0][PW-1:0]  head_tag,
  output logic [CW-1:0]             free_cnt,
  input  logic [1:0]                pop_n,
  input  logic [NPUSH-1:0]          push_en,
  input  logic [NPUSH-1:0][PW-1:0]  push_tag
);
  logic [PW-1:0] mem [NUM_PHYS];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic [NPUSH-1:0][PW-1:0] off;
  logic [CW-1:0] psum;

  // compact the active push slots onto consecutive tail positions
  always_comb begin
    off[0] = '0;
    for (int k = 1; k < NPUSH; k++) off[k] = off[k-1] + PW'(push_en[k-1]);
    psum = CW'(off[NPUSH-1]) + CW'(push_en[NPUSH-1]);
  end

  for (genvar g = 0; g < GROUP; g++) begin : g_head
    assign head_tag[g] = mem[head + PW'(g)];
  end
  assign free_cnt = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem[i] <= (i < INIT_FREE) ? PW'(FIRST_TAG + i) : '0;
      head <= '0;
      tail <= PW'(INIT_FREE);
      cnt  <= CW'(INIT_FREE);
    end else begin
      for (int k = 0; k < NPUSH; k++)
        if (push_en[k]) mem[tail + off[k]] <= push_tag[k];
      head <= head + PW'(pop_n);
      tail <= tail + psum[PW-1:0];
      cnt  <= cnt + psum - CW'(pop_n);
    end
  end

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= cnt);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NUM_PHYS - 1));
  for (genvar k = 0; k < NPUSH; k++) begin : g_pchk
    assert_push_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
      push_en[k] |-> (push_tag[k] != '0));
  end
endmodule

// File: rtl/rn_group_ctl.sv
module rn_group_ctl
  import rename_pkg::*;
#(
  parameter int AW = 5,
  parameter int PW = 6,
  localparam int CW = PW + 1
) (
  input  logic [GROUP-1:0]          in_valid,
  input  logic [GROUP-1:0]          in_has_dst,
  input  logic [GROUP-1:0][AW-1:0]  in_dst,
  input  logic [GROUP-1:0][AW-1:0]  in_src1,
  input  logic [GROUP-1:0][AW-1:0]  in_src2,
  input  logic [GROUP-1:0][PW-1:0]  tbl_s1,
  input  logic [GROUP-1:0][PW-1:0]  tbl_s2,
  input  logic [GROUP-1:0][PW-1:0]  tbl_d,
  input  logic [GROUP-1:0][PW-1:0]  head_tag,
  input  logic [CW-1:0]             free_cnt,
  input  logic                      rec_valid,
  output logic                      stall,
  output logic [GROUP-1:0]          lane_go,
  output logic [GROUP-1:0][PW-1:0]  psrc1,
  output logic [GROUP-1:0][PW-1:0]  psrc2,
  output logic [GROUP-1:0][PW-1:0]  pdst,
  output logic [GROUP-1:0][PW-1:0]  pold,
  output logic [1:0]                pop_n,
  output logic [GROUP-1:0]          map_we
);
  logic [GROUP-1:0] writes;
  logic [1:0] need;

  for (genvar g = 0; g < GROUP; g++) begin : g_wr
    assign writes[g] = in_valid[g] & in_has_dst[g] & (in_dst[g] != '0);
  end

  assign need    = {1'b0, writes[0]} + {1'b0, writes[1]};
  assign stall   = (|in_valid) && (rec_valid || (free_cnt < CW'(need)));
  assign lane_go = in_valid & {GROUP{~stall}};
  assign map_we  = writes & {GROUP{~stall}};
  assign pop_n   = stall ? 2'd0 : need;

  // lane 1 compares against lane 0 in parallel with the table lookup
  logic hit_s1, hit_s2, hit_d;
  assign hit_s1 = writes[0] && (in_src1[1] == in_dst[0]);
  assign hit_s2 = writes[0] && (in_src2[1] == in_dst[0]);
  assign hit_d  = writes[0] && (in_dst[1]  == in_dst[0]);

  always_comb begin
    pdst[0]  = writes[0] ? head_tag[0] : '0;
    pold[0]  = writes[0] ? tbl_d[0] : '0;
    psrc1[0] = tbl_s1[0];
    psrc2[0] = tbl_s2[0];
    pdst[1]  = writes[1] ? (writes[0] ? head_tag[1] : head_tag[0]) : '0;
    pold[1]  = writes[1] ? (hit_d ? pdst[0] : tbl_d[1]) : '0;
    psrc1[1] = hit_s1 ? pdst[0] : tbl_s1[1];
    psrc2[1] = hit_s2 ? pdst[0] : tbl_s2[1];
  end
endmodule

// File: rtl/phys_rename_unit.sv
module phys_rename_unit
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = PW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP-1:0]      in_valid,
  input  logic [GROUP-1:0]      in_has_dst,
  input  logic [GROUP*AW-1:0]   in_dst,
  input  logic [GROUP*AW-1:0]   in_src1,
  input  logic [GROUP*AW-1:0]   in_src2,
  output logic                  stall,
  output logic [GROUP-1:0]      out_valid,
  output logic [GROUP*PW-1:0]   out_psrc1,
  output logic [GROUP*PW-1:0]   out_psrc2,
  output logic [GROUP*PW-1:0]   out_pdst,
  output logic [GROUP*PW-1:0]   out_pold,
  input  logic [GROUP-1:0]      cmt_valid,
  input  logic [GROUP*PW-1:0]   cmt_tag,
  input  logic                  rec_valid,
  input  logic [AW-1:0]         rec_arch,
  input  logic [PW-1:0]         rec_pold,
  input  logic [PW-1:0]         rec_pdst
);
  logic [GROUP-1:0][AW-1:0] dst_a, s1_a, s2_a;
  logic [GROUP-1:0][PW-1:0] cmt_a;
  assign dst_a = in_dst;
  assign s1_a  = in_src1;
  assign s2_a  = in_src2;
  assign cmt_a = cmt_tag;

  logic [NRD-1:0][AW-1:0]   rd_arch;
  logic [NRD-1:0][PW-1:0]   rd_tag;
  logic [GROUP-1:0][PW-1:0] tbl_s1, tbl_s2, tbl_d, head_tag;
  logic [CW-1:0]            free_cnt;
  logic [1:0]               pop_n;
  logic [NPUSH-1:0]         push_en;
  logic [NPUSH-1:0][PW-1:0] push_tag;
  logic [GROUP-1:0]         lane_go, map_we;
  logic [GROUP-1:0][PW-1:0] psrc1, psrc2, pdst, pold;

  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    assign rd_arch[g]           = s1_a[g];
    assign rd_arch[GROUP+g]     = s2_a[g];
    assign rd_arch[2*GROUP+g]   = dst_a[g];
    assign tbl_s1[g]            = rd_tag[g];
    assign tbl_s2[g]            = rd_tag[GROUP+g];
    assign tbl_d[g]             = rd_tag[2*GROUP+g];
    assign push_en[g]           = cmt_valid[g] && (cmt_a[g] != '0);
    assign push_tag[g]          = cmt_a[g];
  end
  assign push_en[GROUP]  = rec_valid && (rec_pdst != '0);
  assign push_tag[GROUP] = rec_pdst;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_map (
    .clk(clk), .rst(rst), .rd_arch(rd_arch), .rd_tag(rd_tag),
    .wr_en(map_we), .wr_arch(dst_a), .wr_tag(pdst),
    .rec_en(rec_valid), .rec_arch(rec_arch), .rec_tag(rec_pold)
  );

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .INIT_FREE(NUM_PHYS - NUM_ARCH),
                 .FIRST_TAG(NUM_ARCH)) u_free (
    .clk(clk), .rst(rst), .head_tag(head_tag), .free_cnt(free_cnt),
    .pop_n(pop_n), .push_en(push_en), .push_tag(push_tag)
  );

  rn_group_ctl #(.AW(AW), .PW(PW)) u_ctl (
    .in_valid(in_valid), .in_has_dst(in_has_dst), .in_dst(dst_a),
    .in_src1(s1_a), .in_src2(s2_a), .tbl_s1(tbl_s1), .tbl_s2(tbl_s2),
    .tbl_d(tbl_d), .head_tag(head_tag), .free_cnt(free_cnt),
    .rec_valid(rec_valid), .stall(stall), .lane_go(lane_go),
    .psrc1(psrc1), .psrc2(psrc2), .pdst(pdst), .pold(pold),
    .pop_n(pop_n), .map_we(map_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_psrc1 <= '0;
      out_psrc2 <= '0;
      out_pdst  <= '0;
      out_pold  <= '0;
    end else begin
      out_valid <= lane_go;
      out_psrc1 <= psrc1;
      out_psrc2 <= psrc2;
      out_pdst  <= pdst;
      out_pold  <= pold;
    end
  end

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> (out_valid == '0));
  assert_distinct_pdst_R3: assert property (@(posedge clk) disable iff (rst)
    ((&out_valid) && out_pdst[PW-1:0] != '0) |->
      (out_pdst[PW-1:0] != out_pdst[2*PW-1:PW]));
  assert_x0_src_R6: assert property (@(posedge clk) disable iff (rst)
    (!stall && in_valid[0] && in_src1[AW-1:0] == '0) |=> (out_psrc1[PW-1:0] == '0));
endmodule

// File: tb/phys_rename_unit_tb.sv
module phys_rename_unit_tb;
  localparam int NA = 32, NP = 64, AW = 5, PW = 6;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [1:0] in_valid = 0, in_has_dst = 0, cmt_valid = 0, out_valid;
  logic [2*AW-1:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic [2*PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold, cmt_tag = 0;
  logic stall, rec_valid = 0;
  logic [AW-1:0] rec_arch = 0;
  logic [PW-1:0] rec_pold = 0, rec_pdst = 0;

  phys_rename_unit u_dut (.*);

  int tests = 0, fails = 0;
  int map_m [NA];
  int fl [$];
  int if_arch [$], if_pd [$], if_po [$];

  bit sv[2], sh[2], cv[2], rv;
  int sd[2], ss1[2], ss2[2], ct[2], ra, rpo, rpd;

  bit ev[2];
  int e_s1[2], e_s2[2], e_pd[2], e_po[2];
  string r_s1[2], r_s2[2], r_pd[2];

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string src_req(int g, int s, bit w0, int d0);
    if (s == 0) return "R6";
    if (g == 1 && w0 && s == d0) return "R5";
    return "R2";
  endfunction

  // one cycle: starts and ends at a falling edge
  task automatic do_cycle();
    bit w[2];
    int need;
    bit st, any;
    for (int g = 0; g < 2; g++) begin
      in_valid[g] = sv[g]; in_has_dst[g] = sh[g];
      in_dst[g*AW +: AW] = AW'(sd[g]);
      in_src1[g*AW +: AW] = AW'(ss1[g]);
      in_src2[g*AW +: AW] = AW'(ss2[g]);
      cmt_valid[g] = cv[g]; cmt_tag[g*PW +: PW] = PW'(ct[g]);
      w[g] = sv[g] && sh[g] && sd[g] != 0;
    end
    rec_valid = rv; rec_arch = AW'(ra); rec_pold = PW'(rpo); rec_pdst = PW'(rpd);
    #1;
    need = int'(w[0]) + int'(w[1]);
    any = sv[0] | sv[1];
    st = any && (rv || fl.size() < need);
    chk(rv ? "R10" : "R8", "stall", int'(stall), int'(st));
    for (int g = 0; g < 2; g++) begin
      ev[g] = sv[g] && !st;
      if (ev[g]) begin
        r_s1[g] = src_req(g, ss1[g], w[0], sd[0]);
        r_s2[g] = src_req(g, ss2[g], w[0], sd[0]);
        e_s1[g] = ss1[g] == 0 ? 0 : map_m[ss1[g]];
        e_s2[g] = ss2[g] == 0 ? 0 : map_m[ss2[g]];
        if (w[g]) begin
          r_pd[g] = (g == 1 && w[0] && sd[1] == sd[0]) ? "R5" : "R3";
          e_po[g] = map_m[sd[g]];
          e_pd[g] = fl.pop_front();
          map_m[sd[g]] = e_pd[g];
          if_arch.push_back(sd[g]); if_pd.push_back(e_pd[g]); if_po.push_back(e_po[g]);
        end else begin
          r_pd[g] = sh[g] ? "R6" : "R7";
          e_pd[g] = 0; e_po[g] = 0;
        end
      end
    end
    for (int c = 0; c < 2; c++) if (cv[c]) fl.push_back(ct[c]);
    if (rv) begin map_m[ra] = rpo; fl.push_back(rpd); end
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk("R11", "out_valid", int'(out_valid[g]), int'(ev[g]));
      if (ev[g]) begin
        chk(r_s1[g], "psrc1", int'(out_psrc1[g*PW +: PW]), e_s1[g]);
        chk(r_s2[g], "psrc2", int'(out_psrc2[g*PW +: PW]), e_s2[g]);
        chk(r_pd[g], "pdst R9", int'(out_pdst[g*PW +: PW]), e_pd[g]);
        chk(r_pd[g] == "R3" ? "R4" : r_pd[g], "pold", int'(out_pold[g*PW +: PW]), e_po[g]);
      end
    end
  endtask

  task automatic clear_stim();
    for (int g = 0; g < 2; g++) begin
      sv[g] = 0; sh[g] = 0; sd[g] = 0; ss1[g] = 0; ss2[g] = 0; cv[g] = 0; ct[g] = 0;
    end
    rv = 0; ra = 0; rpo = 0; rpd = 0;
  endtask

  task automatic rand_group(int range);
    for (int g = 0; g < 2; g++) begin
      sv[g] = $urandom_range(0, 3) != 0;
      sh[g] = $urandom_range(0, 4) != 0;
      sd[g] = $urandom_range(0, range);
      ss1[g] = $urandom_range(0, range);
      ss2[g] = $urandom_range(0, range);
    end
  endtask

  task automatic rand_commit(int pct);
    for (int c = 0; c < 2; c++)
      if (if_po.size() > 0 && $urandom_range(0, 99) < pct) begin
        cv[c] = 1; ct[c] = if_po.pop_front();
        void'(if_arch.pop_front()); void'(if_pd.pop_front());
      end
  endtask

  task automatic recover(int n);
    for (int k = 0; k < n && if_pd.size() > 0; k++) begin
      clear_stim();
      rand_group(7);
      rv = 1; ra = if_arch.pop_back(); rpd = if_pd.pop_back(); rpo = if_po.pop_back();
      do_cycle();
    end
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = NA; i < NP; i++) fl.push_back(i);
    clear_stim();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "stall after reset", int'(stall), 0);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    // directed: RAW and WAW inside one group right after reset
    clear_stim();
    sv[0] = 1; sh[0] = 1; sd[0] = 5; ss1[0] = 3; ss2[0] = 0;
    sv[1] = 1; sh[1] = 1; sd[1] = 5; ss1[1] = 5; ss2[1] = 7;
    @(negedge clk);
    do_cycle();
    chk("R1", "first tag", int'(out_pdst[PW-1:0]), 32);
    chk("R1", "identity map", int'(out_psrc1[PW-1:0]), 3);
    chk("R5", "bypass tag", int'(out_psrc1[PW +: PW]), 32);
    chk("R5", "waw old tag", int'(out_pold[PW +: PW]), 32);
    chk("R3", "second tag", int'(out_pdst[PW +: PW]), 33);
    // no destination and x0 destination
    clear_stim();
    sv[0] = 1; sh[0] = 0; sd[0] = 9; ss1[0] = 5;
    sv[1] = 1; sh[1] = 1; sd[1] = 0; ss1[1] = 0;
    do_cycle();
    chk("R7", "no-dst pdst", int'(out_pdst[PW-1:0]), 0);
    chk("R6", "x0-dst pdst", int'(out_pdst[PW +: PW]), 0);
    // random mix with steady commits
    for (int n = 0; n < 600; n++) begin
      clear_stim(); rand_group(n % 2 == 0 ? 7 : 31);
      if (if_po.size() > 8) rand_commit(60);
      do_cycle();
    end
    // drain the free list with no commits to force stalls
    for (int n = 0; n < 120; n++) begin
      clear_stim(); rand_group(15); do_cycle();
    end
    recover(12);
    for (int rep = 0; rep < 6; rep++) begin
      for (int n = 0; n < 200; n++) begin
        clear_stim(); rand_group(7);
        if (if_po.size() > 4) rand_commit(rep % 2 == 0 ? 30 : 70);
        do_cycle();
      end
      recover($urandom_range(1, 20));
    end
    // commit everything, then keep renaming
    while (if_po.size() > 0) begin
      clear_stim(); rand_commit(100); do_cycle();
    end
    for (int n = 0; n < 100; n++) begin
      clear_stim(); rand_group(31);
      if (if_po.size() > 2) rand_commit(80);
      do_cycle();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule